// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit memory pointers and one 8-bit control byte for an 8-bit processor core. The control byte picks which pointer is active, decides whether each pointer counts up or down when stepped, and enables two automatic behaviours: flipping the pointer choice after pointer-related instructions, and stepping the active pointer after table reads and external data moves. The active pointer is presented on a single output that the core's address path uses.

The instruction decoder drives one strobe per instruction class: pointer increment, load pointer from an immediate, code-table read through the pointer, external read through the pointer, and external write through the pointer. At most one strobe is high per cycle. Separate load ports let software write the control byte and write any byte of either pointer. All updates happen on the rising clock edge that samples the strobe, so the new pointer value and control byte show at the outputs one cycle later.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset both pointers and the control byte are zero, so `active_ptr` and `ctl_q` read 0.
- R2: A control write (`ctl_wr_en`) stores all 8 bits of `ctl_wr_data`, visible on `ctl_q` in the next cycle. Bit positions: 0 = pointer select, 4 = auto-step enable, 5 = auto-toggle enable, 6 = count-down for pointer 0, 7 = count-down for pointer 1.
- R3: A pointer byte write replaces byte `ptr_wr_byte` (0 = bits 7:0, 1 = bits 15:8) of pointer `ptr_wr_sel`; `active_ptr` always shows pointer 0 when control bit 0 is 0 and pointer 1 when it is 1.
- R4: `op_inc` adds 1 to the active pointer when that pointer's count-down bit is 0 and subtracts 1 when it is 1; the other pointer does not change.
- R5: `op_ld_imm` loads `imm_val` into the active pointer only.
- R6: With control bit 5 set, control bit 0 flips after any of the five instruction strobes; with it clear, no strobe changes the control byte.
- R7: With control bit 4 set, `op_movc`, `op_movx_rd` and `op_movx_wr` step the active pointer by one in its counting direction; with bit 4 clear they leave both pointers unchanged; `op_inc` steps exactly once and `op_ld_imm` never steps, whatever bit 4 holds.
- R8: When stepping and toggling happen for one instruction, the step applies to the pointer that was active while the instruction was strobed.
- R9: Steps wrap modulo 2^16: FFFFh counting up gives 0000h and 0000h counting down gives FFFFh.
- R10: A control write in the same cycle as a strobe wins over the toggle for the control byte; a pointer byte write in the same cycle as a strobe that would change that pointer wins, giving the old pointer with only the written byte replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_inc | input | 1 | Pointer increment instruction strobe |
| op_ld_imm | input | 1 | Load pointer from immediate strobe |
| op_movc | input | 1 | Code-table read through pointer strobe |
| op_movx_rd | input | 1 | External read through pointer strobe |
| op_movx_wr | input | 1 | External write through pointer strobe |
| imm_val | input | 16 | Immediate value for `op_ld_imm` |
| ctl_wr_en | input | 1 | Control byte write enable |
| ctl_wr_data | input | 8 | Control byte write value |
| ptr_wr_en | input | 1 | Pointer byte write enable |
| ptr_wr_sel | input | 1 | Pointer chosen for the byte write |
| ptr_wr_byte | input | 1 | Byte lane chosen for the byte write |
| ptr_wr_data | input | 8 | Byte write value |
| ctl_q | output | 8 | Current control byte |
| active_ptr | output | 16 | Value of the active pointer |

## Verification
A wrong select bit shows at once as `active_ptr` presenting the other pointer's value on the cycle after the faulty update, and as bit 0 of `ctl_q`. A wrong step direction, a missed or doubled step, or a step applied to the pointer that became active after a toggle shows as an off-by-one or unchanged pointer value one cycle after the strobe, either on `active_ptr` directly or as soon as the select bit is flipped to bring the other pointer out. Wrap faults only appear at the FFFFh and 0000h boundaries, so the sweep starts pointers there in both counting directions.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  // Control byte field positions (decoded by neighbouring logic)
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned SEL_BIT    = 0;
  localparam int unsigned AUTOSTEP_BIT = 4;
  localparam int unsigned TOGGLE_BIT = 5;
  localparam int unsigned DOWN0_BIT  = 6;
  localparam int unsigned DOWN1_BIT  = 7;

  localparam int unsigned NUM_PTR    = 2;
  localparam int unsigned BYTE_W     = 8;

  // Instruction classes carried by the strobe vector
  typedef enum logic [2:0] {
    OPC_INC   = 3'd0,
    OPC_LDIMM = 3'd1,
    OPC_MOVC  = 3'd2,
    OPC_XRD   = 3'd3,
    OPC_XWR   = 3'd4
  } op_class_e;

  localparam int unsigned NUM_OPS = 5;

  // Which classes step the pointer only when auto-step is on
  function automatic logic is_mem_class(input logic [NUM_OPS-1:0] ops);
    return ops[OPC_MOVC] | ops[OPC_XRD] | ops[OPC_XWR];
  endfunction

endpackage

// File: rtl/dpu_op_decode.sv
module dpu_op_decode
  import dpu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OPS-1:0] ops,
  input  logic               autostep_en,
  input  logic               toggle_en,
  output logic               step_req,
  output logic               load_req,
  output logic               toggle_req
);

  logic any_op;
  logic mem_op;

  always_comb begin
    any_op     = |ops;
    mem_op     = is_mem_class(ops);
    step_req   = ops[OPC_INC] | (mem_op & autostep_en);
    load_req   = ops[OPC_LDIMM];
    toggle_req = any_op & toggle_en;
  end

  AST_OPS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ops)); // R6

  AST_LOAD_NEVER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ops[OPC_LDIMM] |-> !step_req); // R7

endmodule

// File: rtl/dpu_ctl_reg.sv
module dpu_ctl_reg
  import dpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             toggle,
  output logic [CTL_W-1:0] q
);

  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      nxt = wr_data;
    end else if (toggle) begin
      nxt[SEL_BIT] = ~q[SEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data)); // R2

  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !wr_en) |=> q[SEL_BIT] != $past(q[SEL_BIT])); // R6

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !wr_en) |=> $stable(q)); // R6

endmodule

// File: rtl/dpu_ptr_reg.sv
module dpu_ptr_reg
  import dpu_pkg::*;
#(
  parameter int unsigned PTR_W = 16,
  localparam int unsigned LANES = PTR_W / BYTE_W,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             count_down,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             byte_wr_en,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [PTR_W-1:0] q
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // Modulo 2^PTR_W step in either direction
  function automatic logic [PTR_W-1:0] step_value(input logic [PTR_W-1:0] v,
                                                  input logic dn);
    return dn ? (v - ONE) : (v + ONE);
  endfunction

  logic [PTR_W-1:0] spliced;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] nxt;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      spliced[k*BYTE_W +: BYTE_W] = (byte_idx == IDX_W'(k)) ? byte_data
                                                           : q[k*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    stepped = step_value(q, count_down);
    if (byte_wr_en)   nxt = spliced;
    else if (load_en) nxt = load_val;
    else if (step_en) nxt = stepped;
    else              nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en || load_en || byte_wr_en) |=> $stable(q)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !byte_wr_en) |=>
      ($past(count_down) ? (($past(q) - q) == ONE) : ((q - $past(q)) == ONE))); // R4

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !byte_wr_en) |=> q == $past(load_val)); // R5

endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dpu_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             op_inc,
  input  logic                             op_ld_imm,
  input  logic                             op_movc,
  input  logic                             op_movx_rd,
  input  logic                             op_movx_wr,
  input  logic [PTR_W-1:0]                 imm_val,
  input  logic                             ctl_wr_en,
  input  logic [7:0]                       ctl_wr_data,
  input  logic                             ptr_wr_en,
  input  logic                             ptr_wr_sel,
  input  logic [$clog2(PTR_W/8)-1:0]       ptr_wr_byte,
  input  logic [7:0]                       ptr_wr_data,
  output logic [7:0]                       ctl_q,
  output logic [PTR_W-1:0]                 active_ptr
);

  localparam int unsigned IDX_W = $clog2(PTR_W / BYTE_W);

  logic [NUM_OPS-1:0] ops;
  logic               step_req;
  logic               load_req;
  logic               toggle_req;
  logic               sel;
  logic [PTR_W-1:0]   ptr_q [NUM_PTR];

  always_comb begin
    ops             = '0;
    ops[OPC_INC]    = op_inc;
    ops[OPC_LDIMM]  = op_ld_imm;
    ops[OPC_MOVC]   = op_movc;
    ops[OPC_XRD]    = op_movx_rd;
    ops[OPC_XWR]    = op_movx_wr;
  end

  dpu_op_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .ops         (ops),
    .autostep_en (ctl_q[AUTOSTEP_BIT]),
    .toggle_en   (ctl_q[TOGGLE_BIT]),
    .step_req    (step_req),
    .load_req    (load_req),
    .toggle_req  (toggle_req)
  );

  dpu_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .toggle  (toggle_req),
    .q       (ctl_q)
  );

  assign sel = ctl_q[SEL_BIT];

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic is_active;
    logic dn;
    assign is_active = (sel == 1'(p));
    assign dn        = (p == 0) ? ctl_q[DOWN0_BIT] : ctl_q[DOWN1_BIT];

    dpu_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_req & is_active),
      .count_down (dn),
      .load_en    (load_req & is_active),
      .load_val   (imm_val),
      .byte_wr_en (ptr_wr_en && (ptr_wr_sel == 1'(p))),
      .byte_idx   (IDX_W'(ptr_wr_byte)),
      .byte_data  (ptr_wr_data),
      .q          (ptr_q[p])
    );
  end

  assign active_ptr = sel ? ptr_q[1] : ptr_q[0];

  // The pointer that was not active during a strobe keeps its value
  AST_INACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ops) && !ptr_wr_en) |=>
      ($past(sel) ? (ptr_q[0] == $past(ptr_q[0])) : (ptr_q[1] == $past(ptr_q[1])))); // R8

  AST_TOGGLE_MOVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_req && !ctl_wr_en && !ptr_wr_en && !step_req && !load_req) |=>
      active_ptr == ($past(sel) ? $past(ptr_q[0]) : $past(ptr_q[1]))); // R6

endmodule

// File: tb/dptr_pair_unit_tb.sv
module dptr_pair_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_inc = 0, op_ld_imm = 0, op_movc = 0, op_movx_rd = 0, op_movx_wr = 0;
  logic [15:0] imm_val = '0;
  logic        ctl_wr_en = 0;
  logic [7:0]  ctl_wr_data = '0;
  logic        ptr_wr_en = 0, ptr_wr_sel = 0;
  logic [0:0]  ptr_wr_byte = '0;
  logic [7:0]  ptr_wr_data = '0;
  logic [7:0]  ctl_q;
  logic [15:0] active_ptr;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_ptr [2];
  logic [7:0]  m_ctl;

  always #2.5 clk = ~clk;

  dptr_pair_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .op_inc(op_inc), .op_ld_imm(op_ld_imm), .op_movc(op_movc),
    .op_movx_rd(op_movx_rd), .op_movx_wr(op_movx_wr),
    .imm_val(imm_val), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_byte(ptr_wr_byte),
    .ptr_wr_data(ptr_wr_data), .ctl_q(ctl_q), .active_ptr(active_ptr)
  );

  function automatic logic [15:0] exp_step(input logic [15:0] v, input logic dn);
    int t;
    t = dn ? (int'(v) + 65535) : (int'(v) + 1);
    return 16'(t % 65536);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en = 1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 0;
    m_ctl = v;
  endtask

  task automatic wr_byte(input logic p, input logic b, input logic [7:0] d);
    @(negedge clk);
    ptr_wr_en = 1; ptr_wr_sel = p; ptr_wr_byte = b; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 0;
    if (b) m_ptr[p][15:8] = d; else m_ptr[p][7:0] = d;
  endtask

  task automatic set_ptr(input logic p, input logic [15:0] v);
    wr_byte(p, 1'b0, v[7:0]);
    wr_byte(p, 1'b1, v[15:8]);
  endtask

  task automatic drive_op(input int o, input bit on);
    op_inc     = on && (o == 0);
    op_ld_imm  = on && (o == 1);
    op_movc    = on && (o == 2);
    op_movx_rd = on && (o == 3);
    op_movx_wr = on && (o == 4);
  endtask

  // Bench model of one strobe
  task automatic model_op(input int o, input logic [15:0] imm);
    logic a;
    logic dn;
    a  = m_ctl[0];
    dn = a ? m_ctl[7] : m_ctl[6];
    if (o == 0) m_ptr[a] = exp_step(m_ptr[a], dn);
    else if (o == 1) m_ptr[a] = imm;
    else if (m_ctl[4]) m_ptr[a] = exp_step(m_ptr[a], dn);
    if (m_ctl[5]) m_ctl[0] = ~m_ctl[0];
  endtask

  task automatic do_op(input int o, input logic [15:0] imm);
    @(negedge clk);
    imm_val = imm;
    drive_op(o, 1);
    @(negedge clk);
    drive_op(o, 0);
    model_op(o, imm);
  endtask

  // Bring out the non-active pointer by flipping select, then restore
  task automatic chk_other(input string tag);
    logic [7:0] keep;
    keep = m_ctl;
    wr_ctl(keep ^ 8'h01);
    chk(tag, active_ptr, m_ptr[keep[0] ^ 1'b1]);
    wr_ctl(keep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] starts [4];
    starts[0] = 16'h0000; starts[1] = 16'hFFFF; starts[2] = 16'h1234; starts[3] = 16'h8000;
    m_ptr[0] = '0; m_ptr[1] = '0; m_ctl = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", {8'h00, ctl_q}, 16'h0000);
    chk("R1 ptr0", active_ptr, 16'h0000);
    chk_other("R1 ptr1");

    // R2 control write of every bit
    wr_ctl(8'hA5);
    chk("R2 ctl", {8'h00, ctl_q}, 16'h00A5);
    wr_ctl(8'h00);

    // R3 byte writes and select
    set_ptr(1'b0, 16'hBEEF);
    set_ptr(1'b1, 16'hCAFE);
    chk("R3 ptr0", active_ptr, 16'hBEEF);
    wr_ctl(8'h01);
    chk("R3 ptr1", active_ptr, 16'hCAFE);

    // R4 R5 R6 R7 R8 R9: sweep control bits 7:4, select, start values, ops
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 4; v++) begin
          for (int o = 0; o < 5; o++) begin
            set_ptr(1'b0, starts[v]);
            set_ptr(1'b1, starts[(v + 1) % 4] ^ 16'h0F0F);
            wr_ctl(8'(c << 4) | 8'(s));
            do_op(o, 16'h5A00 + 16'(o * 16 + v));
            chk($sformatf("R6 ctl op%0d c%0d", o, c), {8'h00, ctl_q}, {8'h00, m_ctl});
            chk($sformatf("R4 R5 R7 R9 active op%0d c%0d s%0d v%0d", o, c, s, v),
                active_ptr, m_ptr[m_ctl[0]]);
            chk_other($sformatf("R8 other op%0d c%0d s%0d", o, c, s));
          end
        end
      end
    end

    // R9 explicit wrap both ways
    set_ptr(1'b0, 16'hFFFF);
    wr_ctl(8'h00);
    do_op(0, 16'h0);
    chk("R9 up wrap", active_ptr, 16'h0000);
    wr_ctl(8'h40);
    do_op(0, 16'h0);
    chk("R9 down wrap", active_ptr, 16'hFFFF);

    // R10 control write beats toggle; step still applies
    set_ptr(1'b0, 16'h0100);
    wr_ctl(8'h20);
    @(negedge clk);
    op_inc = 1; ctl_wr_en = 1; ctl_wr_data = 8'h00;
    @(negedge clk);
    op_inc = 0; ctl_wr_en = 0;
    m_ctl = 8'h00; m_ptr[0] = 16'h0101;
    chk("R10 ctl wins", {8'h00, ctl_q}, 16'h0000);
    chk("R10 step kept", active_ptr, 16'h0101);

    // R10 byte write beats step on that pointer
    set_ptr(1'b0, 16'h12FF);
    @(negedge clk);
    op_inc = 1; ptr_wr_en = 1; ptr_wr_sel = 0; ptr_wr_byte = 1; ptr_wr_data = 8'hAB;
    @(negedge clk);
    op_inc = 0; ptr_wr_en = 0;
    m_ptr[0] = 16'hABFF;
    chk("R10 byte wins", active_ptr, 16'hABFF);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule